// File: doc/BRIEF.md
# Flash Readout Protection Controller

This block stands between three bus masters (CPU, DMA and the debug port) and the flash read port of a small microcontroller. While reset is held it samples a 16-bit protection word from option storage and latches one of three protection levels: open, read-protected or locked. Every cycle it decides, by master identity and level, whether each pending flash read may reach the flash or must be refused. It also drives the enable for the debug interface.

Read requests use a valid/ready handshake per master. A permitted request waits with ready low until it wins the fixed-priority arbitration and the flash raises `fl_ready`. That is the only source of back-pressure. A refused request completes at once, in the same cycle it is presented, with ready high, an error flag and zero data, and it never reaches the flash. Changes to the protection word arrive on a second valid/ready channel. That channel holds ready low while an erase sequence runs.

The level only tightens freely. Open may move to any level at once. Read-protected may move to open only after the erase engine has finished a full mass erase. Locked rejects every change. Once the debug port has shown activity at read-protected level, CPU and DMA reads are refused as well, so code placed by a debugger cannot read flash indirectly.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low the level is loaded from `opt_word`: 0xA55A gives level 0 (open), 0x33CC gives level 2 (locked), any other value gives level 1 (read-protected). `prot_level` shows it. After reset, `erase_req` is 0, `cfg_wr_ready` is 1 and no master has ready.
- R2: At level 0, requests from all three masters are permitted (master index 0 = CPU, 1 = DMA, 2 = debug; bit i of each per-master vector belongs to master i).
- R3: A refused request gets `m_ready`=1, `m_err`=1 and an all-zero `m_rdata` slice in the same cycle it is presented, and it does not appear on `fl_valid`. At level 1 the debug master is always refused.
- R4: At level 1, CPU and DMA requests are permitted while no debug activity has been recorded since reset.
- R5: A debug-seen flag is set by `dbg_active` or by a debug request in any cycle where `dbg_en` is 1, and it stays set until reset. From the cycle after it is set, CPU and DMA requests at level 1 are refused as in R3.
- R6: At level 2, `dbg_en` is 0, debug requests are refused, CPU and DMA requests are permitted, and `dbg_active` has no effect.
- R7: Among the permitted requests, the lowest master index is forwarded on `fl_valid`/`fl_addr`. It receives `m_ready` and `fl_rdata` only in a cycle where `fl_ready` is 1. Every other permitted request waits with ready low.
- R8: At level 0, an accepted protection-word write sets the level decoded from `cfg_wr_data` from the next cycle on, with no erase.
- R9: At level 1, an accepted write whose value decodes to level 0 starts the erase sequence. `erase_req` is high from the next cycle until `erase_ack` is sampled. The sequence then waits for `erase_done`. The level reads 0 two cycles after the cycle in which `erase_done` is sampled high.
- R10: At level 1, an accepted write whose value decodes to level 1 or 2 takes effect the next cycle without an erase.
- R11: At level 2, every write is accepted with `cfg_wr_rej`=1 in the handshake cycle, and the level stays 2.
- R12: While the erase sequence runs, `cfg_wr_ready` is 0, no request is forwarded to flash, and every master's ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; level loaded while low |
| opt_word | input | 16 | Stored protection word, sampled during reset |
| dbg_active | input | 1 | Debug port activity indication |
| m_valid | input | NM | Read request valid, one bit per master |
| m_addr | input | NM*AW | Read addresses, AW bits per master |
| m_ready | output | NM | Request completion (grant or refusal) per master |
| m_err | output | NM | Refusal flag per master |
| m_rdata | output | NM*DW | Read data per master, zero when refused |
| fl_valid | output | 1 | Forwarded read valid to flash |
| fl_addr | output | AW | Forwarded read address |
| fl_ready | input | 1 | Flash accepts the read and returns data this cycle |
| fl_rdata | input | DW | Flash read data |
| cfg_wr_valid | input | 1 | Protection-word write valid |
| cfg_wr_data | input | 16 | New protection word |
| cfg_wr_ready | output | 1 | Write accepted |
| cfg_wr_rej | output | 1 | Accepted write was rejected |
| erase_req | output | 1 | Mass-erase request to erase engine |
| erase_ack | input | 1 | Erase engine took the request |
| erase_done | input | 1 | Erase engine finished |
| prot_level | output | 2 | Current protection level |
| dbg_en | output | 1 | Debug interface enable |

## Verification
The hardest state to reach from the ports is the read-protected level with the debug-seen flag set. The case that matters is the boundary cycle in which debug activity first appears. There, CPU reads must still pass, and from the following cycle they must fail. The stimulus resets into level 1, presents a debug request alongside a CPU request and expects the CPU grant. It then repeats the CPU request alone and expects a refusal. The erase downgrade is driven step by step: the acknowledge is held back for a cycle, completion is pulsed, and the level, the write ready and the read stall are sampled in each cycle of the sequence.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int CFG_W   = 16;
  localparam int NUM_MST = 3;
  localparam int DBG_MST = 2;

  localparam logic [CFG_W-1:0] CFG_OPEN = 16'hA55A;
  localparam logic [CFG_W-1:0] CFG_LOCK = 16'h33CC;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_RDP  = 2'd1,
    LVL_LOCK = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ERASE_REQ,
    SQ_WAIT_DONE,
    SQ_WRITE_CFG
  } seq_e;

  function automatic lvl_e decode_cfg(input logic [CFG_W-1:0] w);
    if (w == CFG_OPEN)      return LVL_OPEN;
    else if (w == CFG_LOCK) return LVL_LOCK;
    else                    return LVL_RDP;
  endfunction
endpackage

// File: rtl/fg_cfg_seq.sv
module fg_cfg_seq
  import fg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] opt_word,
  input  logic             cfg_wr_valid,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic             cfg_wr_ready,
  output logic             cfg_wr_rej,
  output logic             erase_req,
  input  logic             erase_ack,
  input  logic             erase_done,
  output lvl_e             level,
  output logic             busy
);
  seq_e st_q, st_nx;
  lvl_e lvl_q, lvl_nx, new_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      lvl_q <= decode_cfg(opt_word);
    end else begin
      st_q  <= st_nx;
      lvl_q <= lvl_nx;
    end
  end

  always_comb begin
    st_nx        = st_q;
    lvl_nx       = lvl_q;
    cfg_wr_ready = 1'b0;
    cfg_wr_rej   = 1'b0;
    erase_req    = 1'b0;
    new_lvl      = decode_cfg(cfg_wr_data);
    case (st_q)
      SQ_IDLE: begin
        cfg_wr_ready = 1'b1;
        if (cfg_wr_valid) begin
          if (lvl_q == LVL_LOCK)
            cfg_wr_rej = 1'b1;
          else if (lvl_q == LVL_RDP && new_lvl == LVL_OPEN)
            st_nx = SQ_ERASE_REQ;
          else
            lvl_nx = new_lvl;
        end
      end
      SQ_ERASE_REQ: begin
        erase_req = 1'b1;
        if (erase_ack) st_nx = SQ_WAIT_DONE;
      end
      SQ_WAIT_DONE: begin
        if (erase_done) st_nx = SQ_WRITE_CFG;
      end
      SQ_WRITE_CFG: begin
        lvl_nx = LVL_OPEN;
        st_nx  = SQ_IDLE;
      end
      default: st_nx = SQ_IDLE;
    endcase
  end

  assign level = lvl_q;
  assign busy  = (st_q != SQ_IDLE);
endmodule

// File: rtl/fg_dbg_track.sv
module fg_dbg_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_en,
  input  logic dbg_active,
  input  logic dbg_req,
  output logic dbg_seen
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      seen_q <= 1'b0;
    else if (dbg_en && (dbg_active || dbg_req))
      seen_q <= 1'b1;
  end

  assign dbg_seen = seen_q;
endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import fg_pkg::*;
#(
  parameter int NM  = NUM_MST,
  parameter int DBG = DBG_MST
) (
  input  lvl_e          level,
  input  logic          dbg_seen,
  input  logic          busy,
  input  logic [NM-1:0] m_valid,
  output logic [NM-1:0] cand,
  output logic [NM-1:0] deny
);
  logic [NM-1:0] allow;

  for (genvar g = 0; g < NM; g++) begin : g_mst
    if (g == DBG) begin : g_dbg
      assign allow[g] = (level == LVL_OPEN);
    end else begin : g_bus
      assign allow[g] = (level == LVL_OPEN) || (level == LVL_LOCK) ||
                        (level == LVL_RDP && !dbg_seen);
    end
    assign cand[g] = m_valid[g] && !busy && allow[g];
    assign deny[g] = m_valid[g] && !busy && !allow[g];
  end
endmodule

// File: rtl/fg_arbiter.sv
module fg_arbiter #(
  parameter int NM = 3,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic [NM-1:0]    cand,
  input  logic [NM-1:0]    deny,
  input  logic [NM*AW-1:0] m_addr,
  output logic             fl_valid,
  output logic [AW-1:0]    fl_addr,
  input  logic             fl_ready,
  input  logic [DW-1:0]    fl_rdata,
  output logic [NM-1:0]    m_ready,
  output logic [NM-1:0]    m_err,
  output logic [NM*DW-1:0] m_rdata
);
  logic [NM-1:0] sel;
  logic          found;

  always_comb begin
    sel     = '0;
    found   = 1'b0;
    fl_addr = '0;
    for (int i = 0; i < NM; i++) begin
      if (cand[i] && !found) begin
        sel[i]  = 1'b1;
        found   = 1'b1;
        fl_addr = m_addr[i*AW +: AW];
      end
    end
  end

  assign fl_valid = found;

  for (genvar g = 0; g < NM; g++) begin : g_rsp
    logic take;
    assign take               = sel[g] && fl_ready;
    assign m_ready[g]         = take || deny[g];
    assign m_err[g]           = deny[g];
    assign m_rdata[g*DW +: DW] = take ? fl_rdata : '0;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int NM  = NUM_MST,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int DBG = DBG_MST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      opt_word,
  input  logic             dbg_active,
  input  logic [NM-1:0]    m_valid,
  input  logic [NM*AW-1:0] m_addr,
  output logic [NM-1:0]    m_ready,
  output logic [NM-1:0]    m_err,
  output logic [NM*DW-1:0] m_rdata,
  output logic             fl_valid,
  output logic [AW-1:0]    fl_addr,
  input  logic             fl_ready,
  input  logic [DW-1:0]    fl_rdata,
  input  logic             cfg_wr_valid,
  input  logic [15:0]      cfg_wr_data,
  output logic             cfg_wr_ready,
  output logic             cfg_wr_rej,
  output logic             erase_req,
  input  logic             erase_ack,
  input  logic             erase_done,
  output logic [1:0]       prot_level,
  output logic             dbg_en
);
  lvl_e          level;
  logic          busy;
  logic          dbg_seen;
  logic [NM-1:0] cand, deny;

  fg_cfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .opt_word(opt_word),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_ready(cfg_wr_ready), .cfg_wr_rej(cfg_wr_rej),
    .erase_req(erase_req), .erase_ack(erase_ack), .erase_done(erase_done),
    .level(level), .busy(busy)
  );

  assign dbg_en = (level != LVL_LOCK);

  fg_dbg_track u_dbg (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .dbg_active(dbg_active),
    .dbg_req(m_valid[DBG]), .dbg_seen(dbg_seen)
  );

  fg_policy #(.NM(NM), .DBG(DBG)) u_pol (
    .level(level), .dbg_seen(dbg_seen), .busy(busy),
    .m_valid(m_valid), .cand(cand), .deny(deny)
  );

  fg_arbiter #(.NM(NM), .AW(AW), .DW(DW)) u_arb (
    .cand(cand), .deny(deny), .m_addr(m_addr),
    .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_ready(fl_ready),
    .fl_rdata(fl_rdata), .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata)
  );

  assign prot_level = level;
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int NM  = 3,
  parameter int DW  = 32,
  parameter int DBG = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    m_valid,
  input logic [NM-1:0]    m_ready,
  input logic [NM-1:0]    m_err,
  input logic [NM*DW-1:0] m_rdata,
  input logic             fl_valid,
  input logic             fl_ready,
  input logic             cfg_wr_ready,
  input logic             erase_req,
  input logic             erase_done,
  input logic [1:0]       prot_level,
  input logic             dbg_en
);
  logic [NM*DW-1:0] err_mask;
  logic             done_seen;

  for (genvar g = 0; g < NM; g++) begin : g_mask
    assign err_mask[g*DW +: DW] = {DW{m_err[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 done_seen <= 1'b0;
    else if (erase_done)        done_seen <= 1'b1;
    else if (prot_level == 2'd0) done_seen <= 1'b0;
  end

  AST_DBG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level != 2'd0 && m_valid[DBG] && m_ready[DBG]) |-> m_err[DBG]); // R3
  AST_ERR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (m_err != '0) |-> ((m_err & ~m_ready) == '0)); // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_err != '0) |-> ((m_rdata & err_mask) == '0)); // R3
  AST_LOCK_NO_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level == 2'd2) |-> !dbg_en); // R6
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ready & ~m_err)); // R7
  AST_GRANT_NEEDS_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_ready & ~m_err) != '0) |-> (fl_valid && fl_ready)); // R7
  AST_ERASE_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level == 2'd1 && !done_seen) |=> (prot_level != 2'd0)); // R9
  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level == 2'd2) |=> (prot_level == 2'd2)); // R11
  AST_STALL_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (!fl_valid && !cfg_wr_ready && m_ready == '0)); // R12
endmodule

bind flash_guard fg_checker #(.NM(NM), .DW(DW), .DBG(DBG)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_err(m_err), .m_rdata(m_rdata), .fl_valid(fl_valid), .fl_ready(fl_ready),
  .cfg_wr_ready(cfg_wr_ready), .erase_req(erase_req), .erase_done(erase_done),
  .prot_level(prot_level), .dbg_en(dbg_en)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [DW-1:0] FL_DATA = 32'h5A5A_1234;

  // {opt[27:12], dbg_pre[11], req[10:8], rdy[7:5], err[4:2], lvl[1:0]}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {16'hA55A, 1'b0, 3'b111, 3'b001, 3'b000, 2'd0},
    {16'hA55A, 1'b0, 3'b100, 3'b100, 3'b000, 2'd0},
    {16'hA55A, 1'b1, 3'b110, 3'b010, 3'b000, 2'd0},
    {16'h1234, 1'b0, 3'b111, 3'b101, 3'b100, 2'd1},
    {16'hFFFF, 1'b0, 3'b010, 3'b010, 3'b000, 2'd1},
    {16'h0000, 1'b1, 3'b011, 3'b011, 3'b011, 2'd1},
    {16'hA55B, 1'b0, 3'b100, 3'b100, 3'b100, 2'd1},
    {16'h33CC, 1'b1, 3'b111, 3'b101, 3'b100, 2'd2},
    {16'h33CC, 1'b0, 3'b010, 3'b010, 3'b000, 2'd2},
    {16'h33CD, 1'b0, 3'b001, 3'b001, 3'b000, 2'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      opt_word = 16'hA55A;
  logic             dbg_active = 1'b0;
  logic [NM-1:0]    m_valid = '0;
  logic [NM*AW-1:0] m_addr = {16'h0300, 16'h0200, 16'h0100};
  logic [NM-1:0]    m_ready, m_err;
  logic [NM*DW-1:0] m_rdata;
  logic             fl_valid;
  logic [AW-1:0]    fl_addr;
  logic             fl_ready = 1'b1;
  logic [DW-1:0]    fl_rdata = FL_DATA;
  logic             cfg_wr_valid = 1'b0;
  logic [15:0]      cfg_wr_data = '0;
  logic             cfg_wr_ready, cfg_wr_rej, erase_req;
  logic             erase_ack = 1'b0, erase_done = 1'b0;
  logic [1:0]       prot_level;
  logic             dbg_en;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard #(.NM(NM), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .opt_word(opt_word), .dbg_active(dbg_active),
    .m_valid(m_valid), .m_addr(m_addr), .m_ready(m_ready), .m_err(m_err),
    .m_rdata(m_rdata), .fl_valid(fl_valid), .fl_addr(fl_addr),
    .fl_ready(fl_ready), .fl_rdata(fl_rdata), .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_data(cfg_wr_data), .cfg_wr_ready(cfg_wr_ready),
    .cfg_wr_rej(cfg_wr_rej), .erase_req(erase_req), .erase_ack(erase_ack),
    .erase_done(erase_done), .prot_level(prot_level), .dbg_en(dbg_en)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] w);
    @(negedge clk);
    rst_n = 1'b0; opt_word = w; m_valid = '0; dbg_active = 1'b0;
    cfg_wr_valid = 1'b0; erase_ack = 1'b0; erase_done = 1'b0; fl_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset(16'hA55A);
    #1;
    check("R1 level", prot_level, 2'd0);
    check("R1 erase_req", erase_req, 1'b0);
    check("R1 cfg_wr_ready", cfg_wr_ready, 1'b1);
    check("R1 m_ready", m_ready, 3'b000);

    // Table walk: R1 R2 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic [27:0] v;
      string tg;
      v = VEC[k];
      do_reset(v[27:12]);
      @(negedge clk);
      if (v[11]) begin
        dbg_active = 1'b1;
        @(negedge clk);
        dbg_active = 1'b0;
      end
      m_valid = v[10:8];
      #1;
      if (v[1:0] == 2'd0)      tg = "R2";
      else if (v[1:0] == 2'd2) tg = "R6";
      else if (v[11])          tg = "R5";
      else                     tg = "R4";
      check("R1 table level", prot_level, v[1:0]);
      check({tg, " table ready"}, m_ready, v[7:5]);
      check({tg, " table err"}, m_err, v[4:2]);
      check("R7 table fl_valid", fl_valid, ((v[7:5] & ~v[4:2]) != 3'b000));
      check("R6 table dbg_en", dbg_en, (v[1:0] != 2'd2));
      for (int i = 0; i < NM; i++) begin
        if (v[4+i-2]) check("R3 table zero data", m_rdata[i*DW +: DW], '0);
        else if (v[5+i]) check("R7 table data", m_rdata[i*DW +: DW], FL_DATA);
      end
      @(negedge clk);
      m_valid = '0;
    end

    // R3: debug refused at level 1, nothing forwarded
    do_reset(16'h0000);
    m_valid = 3'b100;
    #1;
    check("R3 ready", m_ready[2], 1'b1);
    check("R3 err", m_err[2], 1'b1);
    check("R3 data", m_rdata[2*DW +: DW], '0);
    check("R3 fl_valid", fl_valid, 1'b0);

    // R5: CPU passes in the cycle debug first shows up, fails afterwards
    do_reset(16'h0000);
    m_valid = 3'b101;
    #1;
    check("R5 same cycle CPU grant", m_ready[0] & ~m_err[0], 1'b1);
    @(negedge clk);
    m_valid = 3'b001;
    #1;
    check("R5 later CPU refused", m_err[0], 1'b1);
    @(negedge clk);
    check("R5 still refused", m_err[0], 1'b1);
    m_valid = '0;

    // R7: back-pressure and priority at level 0
    do_reset(16'hA55A);
    m_valid = 3'b110; fl_ready = 1'b0;
    #1;
    check("R7 stalled ready", m_ready, 3'b000);
    check("R7 fl_valid", fl_valid, 1'b1);
    check("R7 fl_addr DMA wins", fl_addr, 16'h0200);
    @(negedge clk);
    fl_ready = 1'b1;
    #1;
    check("R7 DMA granted", m_ready, 3'b010);
    @(negedge clk);
    m_valid = '0;

    // R8: open -> locked without erase
    cfg_wr_valid = 1'b1; cfg_wr_data = 16'h33CC;
    #1;
    check("R8 accept", {cfg_wr_ready, cfg_wr_rej}, 2'b10);
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    #1;
    check("R8 level", prot_level, 2'd2);
    check("R8 no erase", erase_req, 1'b0);

    // R11: locked rejects
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_data = 16'hA55A;
    #1;
    check("R11 reject", {cfg_wr_ready, cfg_wr_rej}, 2'b11);
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    #1;
    check("R11 level kept", prot_level, 2'd2);
    check("R11 no erase", erase_req, 1'b0);

    // R10: level 1 to level 1 and to level 2 directly
    do_reset(16'h1111);
    cfg_wr_valid = 1'b1; cfg_wr_data = 16'h2222;
    @(negedge clk);
    #1;
    check("R10 stays level 1", prot_level, 2'd1);
    check("R10 no erase", erase_req, 1'b0);
    cfg_wr_data = 16'h33CC;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    #1;
    check("R10 level 2", prot_level, 2'd2);
    check("R10 no erase after", erase_req, 1'b0);

    // R9 / R12: erase sequence
    do_reset(16'h0000);
    cfg_wr_valid = 1'b1; cfg_wr_data = 16'hA55A;
    #1;
    check("R9 accept", {cfg_wr_ready, cfg_wr_rej}, 2'b10);
    @(negedge clk);
    cfg_wr_valid = 1'b0; m_valid = 3'b001;
    #1;
    check("R9 erase_req", erase_req, 1'b1);
    check("R12 write ready low", cfg_wr_ready, 1'b0);
    check("R12 read stalled", {m_ready, fl_valid}, 4'b0000);
    check("R9 level still 1", prot_level, 2'd1);
    @(negedge clk);
    check("R9 erase_req held", erase_req, 1'b1);
    erase_ack = 1'b1;
    @(negedge clk);
    erase_ack = 1'b0;
    #1;
    check("R9 erase_req dropped", erase_req, 1'b0);
    check("R12 waiting stall", {m_ready, fl_valid, cfg_wr_ready}, 5'b00000);
    check("R9 waiting level", prot_level, 2'd1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    #1;
    check("R9 commit cycle level", prot_level, 2'd1);
    @(negedge clk);
    #1;
    check("R9 level open", prot_level, 2'd0);
    check("R9 write ready back", cfg_wr_ready, 1'b1);
    check("R9 CPU read after erase", m_ready, 3'b001);
    m_valid = '0;

    @(negedge clk);
    finish_run();
  end
endmodule